// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is the execution core of a small processor. Seven general registers feed an arithmetic and logic unit over two operand buses, and the unit's result can be written back into one of them. All of this is steered by a 14-bit control word that is presented each clock cycle. The control word selects the source for each bus, the register to load, and the operation to perform. A sequencer elsewhere supplies the control word. An external data port lets fresh values enter the datapath.

The result is combinational. It appears on the output port in the same cycle that the control word and data are applied. The chosen register captures that result on the next rising clock edge. A destination code of zero writes nothing, so the output port can inspect any register or any operation without disturbing stored state.

Top module: `cw_regpath`

## Requirements
- R1: The control word packs four fields from the most significant bit down: bus-A source in bits 13:11, bus-B source in bits 10:8, destination in bits 7:5, and operation code in bits 4:0.
- R2: A source code of 1 to 7 places register Rn on its bus. Code 0 places the external data port on that bus, and this holds for each bus independently.
- R3: A destination code of 1 to 7 loads the result into register Rn on the rising clock edge. Every other register keeps its value, and at most one load enable is active in a cycle.
- R4: A destination code of 0 changes no register, and the result is still driven on the output port.
- R5: The arithmetic codes behave as follows, with sums and differences wrapping modulo 2^DATA_W: 00000 passes A through, 00001 gives A+1, 00010 gives A+B, and 00101 gives A-B.
- R6: The logic codes behave as follows: 01000 gives A AND B, 01010 gives A OR B, 01100 gives A XOR B, and 01110 gives the bitwise complement of A.
- R7: Code 10000 shifts A right by one place and code 11000 shifts A left by one place. In both cases the vacated bit is filled with zero.
- R8: Every operation code not listed in R5 to R7 drives a result of zero.
- R9: A synchronous active-high reset clears all seven registers on the clock edge.
- R10: The control word 010 011 001 00101 computes R2 minus R3 and stores the difference in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register loads occur on the rising edge |
| rst | input | 1 | Synchronous active-high reset that clears all registers |
| ctrl_word | input | 14 | Control word holding the bus-A source, bus-B source, destination and operation fields |
| ext_data | input | DATA_W | External data, selected by source code 0 |
| alu_out | output | DATA_W | Combinational result of the current operation |

## Verification
The bench builds the block with its default DATA_W of 8. At that width, the wrap of add, subtract and increment at 255 is reached often by random operands. The shift carry-out bits at positions 0 and 7 are also exercised regularly. With eight-bit data, the bench can steer every register to its extremes, 0x00 and 0xFF, using directed loads through the external port. Random control words cover all 32 operation codes and every pairing of source and destination codes, including code 0 on both buses at once.

// File: rtl/cw_regpath_pkg.sv
package cw_regpath_pkg;

    localparam int SEL_W = 3;
    localparam int OP_W  = 5;
    localparam int CW_W  = 3 * SEL_W + OP_W;
    localparam int NREG  = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [SEL_W-1:0] src_a;
        logic [SEL_W-1:0] src_b;
        logic [SEL_W-1:0] dest;
        logic [OP_W-1:0]  op;
    } ctrl_t;

    typedef enum logic [OP_W-1:0] {
        OP_PASS  = 5'b00000,
        OP_INC   = 5'b00001,
        OP_ADD   = 5'b00010,
        OP_SUB   = 5'b00101,
        OP_AND   = 5'b01000,
        OP_OR    = 5'b01010,
        OP_XOR   = 5'b01100,
        OP_NOT   = 5'b01110,
        OP_SHR   = 5'b10000,
        OP_SHL   = 5'b11000
    } alu_op_e;

    function automatic logic op_known(logic [OP_W-1:0] c);
        case (c)
            OP_PASS, OP_INC, OP_ADD, OP_SUB, OP_AND,
            OP_OR, OP_XOR, OP_NOT, OP_SHR, OP_SHL: return 1'b1;
            default:                               return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cw_dest_decode.sv
module cw_dest_decode
    import cw_regpath_pkg::*;
(
    input  logic [SEL_W-1:0] dest,
    output logic [NREG-1:0]  load_en
);
    for (genvar g = 0; g < NREG; g++) begin : g_dec
        assign load_en[g] = (dest == SEL_W'(g + 1));
    end
endmodule

// File: rtl/cw_reg_bank.sv
module cw_reg_bank
    import cw_regpath_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NREG-1:0]   load_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  src_a,
    input  logic [SEL_W-1:0]  src_b,
    input  logic [DATA_W-1:0] ext_data,
    output logic [DATA_W-1:0] bus_a,
    output logic [DATA_W-1:0] bus_b
);
    logic [NREG-1:0][DATA_W-1:0] regs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (load_en[i]) regs_q[i] <= wr_data;
            end
        end
    end

    always_comb begin
        bus_a = ext_data;
        bus_b = ext_data;
        for (int k = 1; k <= NREG; k++) begin
            if (src_a == SEL_W'(k)) bus_a = regs_q[k-1];
            if (src_b == SEL_W'(k)) bus_b = regs_q[k-1];
        end
    end
endmodule

// File: rtl/cw_alu.sv
module cw_alu
    import cw_regpath_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] result
);
    always_comb begin
        case (op)
            OP_PASS: result = opa;
            OP_INC:  result = opa + DATA_W'(1);
            OP_ADD:  result = opa + opb;
            OP_SUB:  result = opa - opb;
            OP_AND:  result = opa & opb;
            OP_OR:   result = opa | opb;
            OP_XOR:  result = opa ^ opb;
            OP_NOT:  result = ~opa;
            OP_SHR:  result = {1'b0, opa[DATA_W-1:1]};
            OP_SHL:  result = {opa[DATA_W-2:0], 1'b0};
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/cw_regpath.sv
module cw_regpath
    import cw_regpath_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CW_W-1:0]   ctrl_word,
    input  logic [DATA_W-1:0] ext_data,
    output logic [DATA_W-1:0] alu_out
);
    ctrl_t             cw;
    logic [NREG-1:0]   load_en;
    logic [DATA_W-1:0] bus_a;
    logic [DATA_W-1:0] bus_b;
    logic [DATA_W-1:0] result;

    assign cw = ctrl_t'(ctrl_word);

    cw_dest_decode u_dec (
        .dest    (cw.dest),
        .load_en (load_en)
    );

    cw_reg_bank #(.DATA_W(DATA_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_en),
        .wr_data  (result),
        .src_a    (cw.src_a),
        .src_b    (cw.src_b),
        .ext_data (ext_data),
        .bus_a    (bus_a),
        .bus_b    (bus_b)
    );

    cw_alu #(.DATA_W(DATA_W)) u_alu (
        .op     (cw.op),
        .opa    (bus_a),
        .opb    (bus_b),
        .result (result)
    );

    assign alu_out = result;
endmodule

// File: rtl/cw_regpath_chk.sv
module cw_regpath_chk
    import cw_regpath_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [CW_W-1:0]   ctrl_word,
    input logic [DATA_W-1:0] ext_data,
    input logic [DATA_W-1:0] alu_out,
    input logic [NREG-1:0]   load_en
);
    logic [SEL_W-1:0] f_a, f_b, f_d;
    logic [OP_W-1:0]  f_op;
    assign f_a  = ctrl_word[13:11];
    assign f_b  = ctrl_word[10:8];
    assign f_d  = ctrl_word[7:5];
    assign f_op = ctrl_word[4:0];

    AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load_en)); // R3

    AST_NO_WRITE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (f_d == '0) |-> (load_en == '0)); // R4

    AST_EXT_PASS: assert property (@(posedge clk) disable iff (rst)
        (f_a == '0 && f_op == OP_PASS) |-> (alu_out == ext_data)); // R2

    AST_UNKNOWN_ZERO: assert property (@(posedge clk) disable iff (rst)
        !op_known(f_op) |-> (alu_out == '0)); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && f_a != '0 && f_op == OP_PASS) |-> (alu_out == '0)); // R9

    AST_STORE_READBACK: assert property (@(posedge clk) disable iff (rst)
        (f_d != '0 && f_a == '0 && f_op == OP_PASS)
        |=> (!(f_a == $past(f_d) && f_op == OP_PASS) || alu_out == $past(ext_data))); // R3
endmodule

bind cw_regpath cw_regpath_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl_word (ctrl_word),
    .ext_data  (ext_data),
    .alu_out   (alu_out),
    .load_en   (load_en)
);

// File: tb/cw_regpath_tb.sv
`timescale 1ns/1ps
module cw_regpath_tb;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [13:0]   ctrl_word = '0;
    logic [DW-1:0] ext_data = '0;
    logic [DW-1:0] alu_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [DW-1:0] model [1:7];

    always #2.5 clk = ~clk;

    cw_regpath #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .ctrl_word(ctrl_word),
        .ext_data(ext_data), .alu_out(alu_out)
    );

    function automatic logic [DW-1:0] src_val(logic [2:0] s, logic [DW-1:0] e);
        return (s == 3'd0) ? e : model[s];
    endfunction

    function automatic logic [DW-1:0] expect_alu(logic [13:0] w, logic [DW-1:0] e);
        logic [DW-1:0] a, b;
        a = src_val(w[13:11], e);
        b = src_val(w[10:8], e);
        case (w[4:0])
            5'b00000: return a;
            5'b00001: return a + 8'd1;
            5'b00010: return a + b;
            5'b00101: return a - b;
            5'b01000: return a & b;
            5'b01010: return a | b;
            5'b01100: return a ^ b;
            5'b01110: return ~a;
            5'b10000: return a >> 1;
            5'b11000: return a << 1;
            default:  return '0;
        endcase
    endfunction

    function automatic string req_of(logic [4:0] op);
        case (op)
            5'b00000, 5'b00001, 5'b00010, 5'b00101: return "R5";
            5'b01000, 5'b01010, 5'b01100, 5'b01110: return "R6";
            5'b10000, 5'b11000:                     return "R7";
            default:                                return "R8";
        endcase
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // apply one control word, check the result, then let the edge load it
    task automatic step(logic [13:0] w, logic [DW-1:0] e, string req);
        logic [DW-1:0] exp;
        @(negedge clk);
        ctrl_word = w;
        ext_data  = e;
        #1;
        exp = expect_alu(w, e);
        check(req, alu_out, exp);
        if (w[7:5] != 3'd0) model[w[7:5]] = exp;
        @(posedge clk);
    endtask

    task automatic load_reg(int n, logic [DW-1:0] v);
        step({3'd0, 3'd0, 3'(n), 5'b00000}, v, "R2");
    endtask

    task automatic read_all(string req);
        for (int n = 1; n <= 7; n++)
            step({3'(n), 3'd0, 3'd0, 5'b00000}, 8'h5A, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ctrl_word = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int n = 1; n <= 7; n++) model[n] = '0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [4:0] ops [10];
        logic [13:0] w;
        void'($urandom(32'h00C0FFEE));
        ops = '{5'b00000, 5'b00001, 5'b00010, 5'b00101, 5'b01000,
                5'b01010, 5'b01100, 5'b01110, 5'b10000, 5'b11000};

        do_reset();
        read_all("R9");

        // R10 and R1: packed example word, fields at 13:11, 10:8, 7:5, 4:0
        load_reg(2, 8'd50);
        load_reg(3, 8'd20);
        step(14'b010_011_001_00101, 8'h00, "R10");
        step({3'd1, 3'd0, 3'd0, 5'b00000}, 8'h00, "R10");
        check("R1", model[1], 8'd30);

        // wrap corners, R5
        load_reg(4, 8'hFF);
        step({3'd4, 3'd0, 3'd0, 5'b00001}, 8'h00, "R5");
        step({3'd4, 3'd0, 3'd0, 5'b00010}, 8'h01, "R5");
        step({3'd0, 3'd4, 3'd0, 5'b00101}, 8'h00, "R5");
        // shift carry-out corners, R7
        step({3'd4, 3'd0, 3'd0, 5'b10000}, 8'h00, "R7");
        step({3'd0, 3'd0, 3'd0, 5'b11000}, 8'h81, "R7");
        // undefined code, R8
        step({3'd4, 3'd4, 3'd0, 5'b11111}, 8'h00, "R8");
        step({3'd4, 3'd4, 3'd5, 5'b00011}, 8'h00, "R8");
        // logic with both buses from ext, R2 and R6
        step({3'd0, 3'd0, 3'd0, 5'b01100}, 8'hA5, "R6");
        step({3'd0, 3'd0, 3'd0, 5'b01110}, 8'hA5, "R6");

        // R4: destination 0 with a nonzero result leaves registers intact
        step({3'd0, 3'd0, 3'd0, 5'b00000}, 8'hEE, "R4");
        read_all("R4");

        // random mix, R3 readback of every register at intervals
        for (int i = 0; i < 3000; i++) begin
            w[13:11] = 3'($urandom_range(0, 7));
            w[10:8]  = 3'($urandom_range(0, 7));
            w[7:5]   = 3'($urandom_range(0, 7));
            w[4:0]   = ($urandom_range(0, 9) == 0) ? 5'($urandom) : ops[$urandom_range(0, 9)];
            step(w, DW'($urandom), req_of(w[4:0]));
            if (i % 300 == 299) read_all("R3");
        end

        // R9: reset mid-run after loading nonzero values
        for (int n = 1; n <= 7; n++) load_reg(n, 8'(n * 17 + 3));
        do_reset();
        read_all("R9");

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule